// File: doc/BRIEF.md
# Prescaled PWM Channel Group

This block generates four pulse-width-modulated outputs from one system clock. The channels form two pairs, and each pair shares an 8-bit prescaler. The prescaler feeds a per-channel power-of-two divider. The divider output is the count tick for a 16-bit counter. That counter runs in one of two modes, chosen per pair. In the saw-tooth mode it counts down. In the triangle mode it counts up and then back down. Each output is high while the counter does not exceed the channel's compare value, and an optional per-channel inversion can complement it.

Software programs the block through a single-cycle register write port. Period and compare values go to shadow registers. A running channel copies them into its working registers only at the start of a new period, so an update never cuts a period short. Each channel also has a sticky period-event flag. A per-pair type bit sets the event that raises it: the counter reaching the bottom of its range, or the counter meeting the period value. A per-channel enable gates the flag, and writing a one to the clear register clears it.

Top module: `pwm_quad_timer`

## Requirements
- R1: During and after reset all outputs are 0 and all internal settings are 0, which includes the divider selects (code 0) and the shadow and working periods.
- R2: Channels 0 and 1 share the prescaler at address 0, and channels 2 and 3 share the one at address 1, using bits [7:0]. A value x>0 produces one prescaler tick every x+1 clock cycles. A value of 0 produces no ticks, so both counters of that pair and their outputs and flags freeze.
- R3: The divider select for channel n is at address 2, bits [3n+2:3n]. It passes one tick per N prescaler ticks, where code 4 gives N=1, 0 gives N=2, 1 gives N=4, 2 gives N=8, 3 gives N=16, and the codes 5, 6 and 7 give N=1. The divider is held at its start while the channel is stopped.
- R4: In edge-aligned mode (pair bit 0) a running counter steps down by one per tick. On the tick at zero it reloads the period value, so one period lasts P+1 ticks.
- R5: In center-aligned mode (pair bit 1) a running counter rises from 0 to P and falls back to 0, so one period lasts 2P ticks. A new period begins on the tick at 0 while falling, which moves the counter to 1.
- R6: Before inversion, an output is 1 only while its channel runs, its working period is nonzero and its counter is less than or equal to its working compare value.
- R7: When inversion is enabled for a channel, its output is the complement of the value R6 defines, including while the channel is stopped.
- R8: Written period and compare values reach a running channel only at the start of its next period. A stopped channel copies them one cycle after they are written. A stopped edge counter sits at the shadow period, and a stopped center counter sits at 0.
- R9: While the working period is 0 the counter stays at 0, no period event occurs, and the shadow values are copied on every tick.
- R10: Address 3 holds the control fields: run bits [3:0], inversion [7:4], pair mode [9:8] and pair event type [11:10]. Event type 0 selects the bottom event, which is the reload tick at 0. Event type 1 selects the match event, which is the tick on which the counter holds the period value (while rising, in center mode).
- R11: A channel's flag is set by its selected event only if its enable bit (address 4, bit n) is 1. It stays set until a one is written to bit n of address 5. If a set and a clear fall in the same cycle, the set wins.
- R12: The period of channel n is at address 8+2n and its compare value at address 9+2n. Under random programming of all fields, every output and flag follows R2 to R11 cycle by cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 4 | PWM outputs after inversion, one per channel |
| irq_flag | output | 4 | Sticky period-event flags, one per channel |

## Verification
A register write takes effect at the clock edge that samples it. The first counter, output or flag change it can cause appears after the following edge. A divider or prescaler tick moves a counter, an output and a flag together at one edge, with no extra stage in between. The bench updates its reference state at each rising edge, in the same order as that edge: it evaluates the events and flags from the old state, then applies the write. It compares every output and flag at the falling edge that follows. A few directed checks look at freezes and clears over windows of several hundred cycles, sampled at falling edges after the write has settled.

// File: rtl/pwm_quad_pkg.sv
// Shared constants, types and the divider code table for the PWM group.
package pwm_quad_pkg;
    localparam int NUM_CH   = 4;
    localparam int NUM_PAIR = NUM_CH / 2;
    localparam int SEL_W    = 3;
    localparam int ADDR_W   = 4;

    localparam logic [ADDR_W-1:0] A_PSC_LO   = 4'd0;
    localparam logic [ADDR_W-1:0] A_PSC_HI   = 4'd1;
    localparam logic [ADDR_W-1:0] A_DIVSEL   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd3;
    localparam logic [ADDR_W-1:0] A_IRQ_EN   = 4'd4;
    localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 4'd5;
    localparam int                A_PER_BASE = 8;

    typedef enum logic { ALIGN_EDGE = 1'b0, ALIGN_CENTER = 1'b1 } align_e;
    typedef enum logic { EVT_BOTTOM = 1'b0, EVT_MATCH = 1'b1 } evt_src_e;

    // Terminal count (ratio minus one) for a divider select code.
    function automatic logic [3:0] div_last(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    div_last = 4'd1;
            3'd1:    div_last = 4'd3;
            3'd2:    div_last = 4'd7;
            3'd3:    div_last = 4'd15;
            default: div_last = 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
// Shared pair prescaler: emits one tick every psc+1 clocks; psc==0 halts it.
// Assumes psc may change at any time; a count past the new limit wraps at once.
module pwm_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] pc_q;

    assign tick = (psc != '0) && (pc_q >= psc);

    // Free-running clock counter, cleared on tick or while halted.
    always_ff @(posedge clk) begin
        if (!rst_n)            pc_q <= '0;
        else if (psc == '0)    pc_q <= '0;
        else if (tick)         pc_q <= '0;
        else                   pc_q <= pc_q + 1'b1;
    end

    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    a_r2_zero_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (psc == '0) |=> (pc_q == '0));
endmodule

// File: rtl/pwm_divider.sv
// Per-channel divider: passes every N-th prescaler tick, N from the select code.
// Assumes clr is held while the channel is stopped so each run starts aligned.
module pwm_divider import pwm_quad_pkg::*; (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    input  logic             in_tick,
    output logic             out_tick
);
    logic [3:0] dc_q;

    assign out_tick = in_tick && (dc_q >= div_last(sel));

    // Count prescaler ticks, restarting after each passed tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  dc_q <= '0;
        else if (in_tick)   dc_q <= out_tick ? 4'd0 : dc_q + 4'd1;
    end

    a_r3_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dc_q == '0));
endmodule

// File: rtl/pwm_channel.sv
// One PWM channel: double-buffered period/compare, edge or center counter,
// raw output and single-cycle period events. Assumes tick is a one-cycle pulse.
module pwm_channel import pwm_quad_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  align_e           align,
    input  logic             tick,
    input  logic [CNT_W-1:0] sh_per,
    input  logic [CNT_W-1:0] sh_cmp,
    output logic             pwm_raw,
    output logic             ev_bottom,
    output logic             ev_match
);
    logic [CNT_W-1:0] cnt_q, cnt_d, per_q, cmp_q;
    logic             up_q, up_d, load;

    // Next counter state, direction, buffer load and events.
    always_comb begin
        cnt_d     = cnt_q;
        up_d      = up_q;
        load      = 1'b0;
        ev_bottom = 1'b0;
        ev_match  = 1'b0;
        if (!run) begin
            load  = 1'b1;
            up_d  = 1'b1;
            cnt_d = (align == ALIGN_CENTER) ? '0 : sh_per;
        end else if (tick) begin
            if (align == ALIGN_EDGE) begin
                ev_match = (per_q != '0) && (cnt_q == per_q);
                if (cnt_q == '0) begin
                    load      = 1'b1;
                    cnt_d     = sh_per;
                    ev_bottom = (per_q != '0);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end else if (per_q == '0) begin
                load  = 1'b1;
                up_d  = 1'b1;
                cnt_d = '0;
            end else if (up_q) begin
                if (cnt_q == per_q) begin
                    ev_match = 1'b1;
                    up_d     = 1'b0;
                    cnt_d    = cnt_q - 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end else if (cnt_q == '0) begin
                load      = 1'b1;
                up_d      = 1'b1;
                ev_bottom = 1'b1;
                cnt_d     = (sh_per != '0) ? CNT_W'(1) : '0;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    // Counter, direction and working period/compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
            per_q <= '0;
            cmp_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            up_q  <= up_d;
            if (load) begin
                per_q <= sh_per;
                cmp_q <= sh_cmp;
            end
        end
    end

    assign pwm_raw = run && (per_q != '0) && (cnt_q <= cmp_q);

    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_q);
    a_r8_hold_buffers: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> ($stable(per_q) && $stable(cmp_q)));
    a_r5_turns_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && align == ALIGN_CENTER && up_q && per_q != '0 && cnt_q == per_q)
        |=> !up_q);
    a_r9_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == '0) |-> (!ev_bottom && !ev_match));
    a_r6_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_raw);
endmodule

// File: rtl/pwm_quad_timer.sv
// Four-channel prescaled PWM group with a single-cycle register write port.
// Holds the register file and sticky flags; assumes wr_* are synchronous to clk.
module pwm_quad_timer import pwm_quad_pkg::*; #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] irq_flag
);
    localparam int INV_LSB = NUM_CH;
    localparam int ALN_LSB = 2 * NUM_CH;
    localparam int SRC_LSB = 2 * NUM_CH + NUM_PAIR;

    logic [PSC_W-1:0]        psc_q  [NUM_PAIR];
    logic [SEL_W*NUM_CH-1:0] sel_q;
    logic [NUM_CH-1:0]       run_q, inv_q, ien_q, clr, set;
    logic [NUM_PAIR-1:0]     aln_q, src_q, ptick;

    // Shared configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            run_q <= '0;
            inv_q <= '0;
            aln_q <= '0;
            src_q <= '0;
            ien_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_DIVSEL) sel_q <= wr_data[SEL_W*NUM_CH-1:0];
            if (wr_addr == A_IRQ_EN) ien_q <= wr_data[NUM_CH-1:0];
            if (wr_addr == A_CTRL) begin
                run_q <= wr_data[NUM_CH-1:0];
                inv_q <= wr_data[INV_LSB +: NUM_CH];
                aln_q <= wr_data[ALN_LSB +: NUM_PAIR];
                src_q <= wr_data[SRC_LSB +: NUM_PAIR];
            end
        end
    end

    assign clr = (wr_en && wr_addr == A_IRQ_CLR) ? wr_data[NUM_CH-1:0] : '0;

    // Sticky period-event flags; a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_flag <= '0;
        else        irq_flag <= (irq_flag & ~clr) | set;
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        localparam logic [ADDR_W-1:0] A_PSC = ADDR_W'(p);

        // Prescaler value of this pair.
        always_ff @(posedge clk) begin
            if (!rst_n)                         psc_q[p] <= '0;
            else if (wr_en && wr_addr == A_PSC) psc_q[p] <= wr_data[PSC_W-1:0];
        end

        pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
            .clk  (clk),
            .rst_n(rst_n),
            .psc  (psc_q[p]),
            .tick (ptick[p])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(A_PER_BASE + 2 * c);
        localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(A_PER_BASE + 2 * c + 1);
        localparam int                PAIR  = c / 2;

        logic [CNT_W-1:0] sh_per_q, sh_cmp_q;
        logic             dtick, raw, ev_b, ev_m;
        align_e           aln;
        evt_src_e         src;

        // Shadow period and compare registers.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_per_q <= '0;
                sh_cmp_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == A_PER) sh_per_q <= wr_data;
                if (wr_addr == A_CMP) sh_cmp_q <= wr_data;
            end
        end

        assign aln = align_e'(aln_q[PAIR]);
        assign src = evt_src_e'(src_q[PAIR]);

        pwm_divider u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (!run_q[c]),
            .sel     (sel_q[SEL_W*c +: SEL_W]),
            .in_tick (ptick[PAIR]),
            .out_tick(dtick)
        );

        pwm_channel #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[c]),
            .align    (aln),
            .tick     (dtick),
            .sh_per   (sh_per_q),
            .sh_cmp   (sh_cmp_q),
            .pwm_raw  (raw),
            .ev_bottom(ev_b),
            .ev_match (ev_m)
        );

        assign set[c]     = ien_q[c] && ((src == EVT_MATCH) ? ev_m : ev_b);
        assign pwm_out[c] = raw ^ inv_q[c];

        a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_flag[c] && !clr[c]) |=> irq_flag[c]);
        a_r11_gated: assert property (@(posedge clk) disable iff (!rst_n)
            (!ien_q[c] && !irq_flag[c]) |=> !irq_flag[c]);
        a_r7_inverted_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[c] && inv_q[c]) |-> pwm_out[c]);
    end
endmodule

// File: tb/pwm_quad_timer_bench.sv
module pwm_quad_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm_out, irq_flag;

    int    checks = 0, fails = 0, cyc = 0;
    bit    chk_on = 1'b0, done = 1'b0;
    string cur_req = "R1";

    // Reference state
    int m_psc [2], m_pc [2];
    int m_sel [4], m_dc [4], m_sper [4], m_scmp [4], m_aper [4], m_acmp [4], m_cnt [4];
    bit m_up [4];
    bit [15:0] m_ctrl;
    bit [3:0]  m_en, m_flag;

    always #2 clk = ~clk;

    pwm_quad_timer u_pwm_quad_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .irq_flag(irq_flag)
    );

    function automatic int last_of(input int code);
        case (code)
            0: return 1;
            1: return 3;
            2: return 7;
            3: return 15;
            default: return 0;
        endcase
    endfunction

    function automatic bit [3:0] exp_out();
        bit [3:0] r;
        for (int c = 0; c < 4; c++)
            r[c] = (m_ctrl[c] && m_aper[c] != 0 && m_cnt[c] <= m_acmp[c]) ^ m_ctrl[4+c];
        return r;
    endfunction

    // Reference update at each rising edge: old state first, then the write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin m_psc[i] = 0; m_pc[i] = 0; end
            for (int c = 0; c < 4; c++) begin
                m_sel[c] = 0; m_dc[c] = 0; m_sper[c] = 0; m_scmp[c] = 0;
                m_aper[c] = 0; m_acmp[c] = 0; m_cnt[c] = 0; m_up[c] = 1;
            end
            m_ctrl = 0; m_en = 0; m_flag = 0;
        end else begin
            bit ptk [2];
            bit [3:0] st, cl;
            st = 0;
            for (int i = 0; i < 2; i++) ptk[i] = (m_psc[i] != 0) && (m_pc[i] >= m_psc[i]);
            for (int c = 0; c < 4; c++) begin
                bit run, ctr, typ, dt, ld, eb, em;
                int nc;
                run = m_ctrl[c]; ctr = m_ctrl[8+c/2]; typ = m_ctrl[10+c/2];
                dt = ptk[c/2] && (m_dc[c] >= last_of(m_sel[c]));
                if (!run) m_dc[c] = 0;
                else if (ptk[c/2]) m_dc[c] = dt ? 0 : m_dc[c] + 1;
                ld = 0; eb = 0; em = 0; nc = m_cnt[c];
                if (!run) begin
                    ld = 1; m_up[c] = 1; nc = ctr ? 0 : m_sper[c];
                end else if (dt) begin
                    if (!ctr) begin
                        em = (m_aper[c] != 0) && (m_cnt[c] == m_aper[c]);
                        if (m_cnt[c] == 0) begin ld = 1; nc = m_sper[c]; eb = (m_aper[c] != 0); end
                        else nc = m_cnt[c] - 1;
                    end else if (m_aper[c] == 0) begin
                        ld = 1; m_up[c] = 1; nc = 0;
                    end else if (m_up[c]) begin
                        if (m_cnt[c] == m_aper[c]) begin em = 1; m_up[c] = 0; nc = m_cnt[c] - 1; end
                        else nc = m_cnt[c] + 1;
                    end else if (m_cnt[c] == 0) begin
                        ld = 1; m_up[c] = 1; eb = 1; nc = (m_sper[c] != 0) ? 1 : 0;
                    end else nc = m_cnt[c] - 1;
                end
                m_cnt[c] = nc;
                if (ld) begin m_aper[c] = m_sper[c]; m_acmp[c] = m_scmp[c]; end
                st[c] = m_en[c] && (typ ? em : eb);
            end
            cl = (wr_en && wr_addr == 4'd5) ? wr_data[3:0] : 4'd0;
            m_flag = (m_flag & ~cl) | st;
            for (int i = 0; i < 2; i++) begin
                if (m_psc[i] == 0 || ptk[i]) m_pc[i] = 0;
                else m_pc[i] = m_pc[i] + 1;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: m_psc[0] = wr_data[7:0];
                    4'd1: m_psc[1] = wr_data[7:0];
                    4'd2: for (int c = 0; c < 4; c++) m_sel[c] = (wr_data >> (3*c)) & 7;
                    4'd3: m_ctrl = wr_data;
                    4'd4: m_en = wr_data[3:0];
                    default: if (wr_addr >= 8) begin
                        if (wr_addr[0]) m_scmp[(wr_addr-8)/2] = wr_data;
                        else            m_sper[(wr_addr-8)/2] = wr_data;
                    end
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(cur_req, pwm_out, exp_out(), "pwm_out");
            check(cur_req, irq_flag, m_flag, "irq_flag");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [3:0] held_o, held_f;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check("R1", pwm_out, 4'h0, "reset pwm_out");
        check("R1", irq_flag, 4'h0, "reset irq_flag");
        rst_n = 1'b1;
        chk_on = 1'b1;

        cur_req = "R4";
        wr(4'd0, 16'd1);
        wr(4'd2, 16'd1092);              // codes: ch0 4, ch1 0, ch2 1, ch3 2
        wr(4'd8, 16'd5); wr(4'd9, 16'd2);
        wr(4'd4, 16'hF);
        wr(4'd3, 16'h0001);
        idle(100);

        cur_req = "R3";
        wr(4'd1, 16'd1);
        for (int c = 1; c < 4; c++) begin wr(4'(8+2*c), 16'd3); wr(4'(9+2*c), 16'd1); end
        wr(4'd3, 16'h000F);
        idle(400);
        wr(4'd2, 16'(3 | (5 << 3) | (7 << 6) | (6 << 9)));
        idle(400);

        cur_req = "R5";
        wr(4'd3, 16'h030F);
        idle(400);

        cur_req = "R8";
        wr(4'd8, 16'd9); wr(4'd9, 16'd4);
        idle(300);

        cur_req = "R10";
        wr(4'd3, 16'h0F0F);
        idle(300);

        cur_req = "R7";
        wr(4'd3, 16'h0FFF);
        idle(200);
        wr(4'd3, 16'h00F0);
        idle(2);
        check("R7", pwm_out, 4'hF, "stopped inverted");

        cur_req = "R9";
        wr(4'd10, 16'd0);
        wr(4'd3, 16'h000F);
        idle(200);

        cur_req = "R11";
        wr(4'd3, 16'h0000);
        wr(4'd5, 16'hF);
        idle(1);
        check("R11", irq_flag, 4'h0, "cleared flags");
        wr(4'd4, 16'h0);
        wr(4'd3, 16'h000F);
        idle(300);
        check("R11", irq_flag, 4'h0, "disabled flags");
        wr(4'd4, 16'hF);
        idle(200);

        cur_req = "R2";
        wr(4'd1, 16'd0);
        idle(2);
        held_o = pwm_out; held_f = irq_flag;
        idle(300);
        check("R2", pwm_out & 4'hC, held_o & 4'hC, "halted pair outputs");
        check("R2", irq_flag & 4'hC, held_f & 4'hC, "halted pair flags");
        wr(4'd1, 16'd3);
        idle(100);

        cur_req = "R12";
        for (int r = 0; r < 20; r++) begin
            wr(4'd3, 16'h0000);
            wr(4'd0, 16'(($urandom % 5 == 0) ? 0 : 1 + $urandom % 3));
            wr(4'd1, 16'(($urandom % 5 == 0) ? 0 : 1 + $urandom % 3));
            wr(4'd2, 16'($urandom & 16'h0FFF));
            for (int c = 0; c < 4; c++) begin
                wr(4'(8+2*c), 16'($urandom % 21));
                wr(4'(9+2*c), 16'($urandom % 23));
            end
            wr(4'd4, 16'($urandom & 4'hF));
            wr(4'd3, 16'($urandom & 16'h0FFF));
            for (int k = 0; k < 6; k++) begin
                idle(40 + $urandom % 60);
                case ($urandom % 3)
                    0: wr(4'(8 + ($urandom % 8)), 16'($urandom % 21));
                    1: wr(4'd5, 16'($urandom & 4'hF));
                    default: wr(4'd3, 16'($urandom & 16'h0FFF));
                endcase
            end
        end

        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule